// File: doc/BRIEF.md
# Time-Shared Multiply-Accumulate FIR Filter

This block is a sample-at-a-time finite impulse response filter with `TAPS` coefficients. Each accepted input sample is written into a circular delay memory at the slot a write pointer selects. That slot always holds the sample that has just dropped out of the filter's window, so stored samples are never moved. A single multiply-accumulate unit then walks the taps one per clock. It pairs coefficient `b[n]` with the sample that arrived `n` samples earlier, starting from the newest sample and `b[0]`. The accumulator carries high-order guard bits so that partial sums may leave the data range.

Samples, coefficients and results are `DATA_W`-bit two's-complement fractions. The accumulated result is rounded by half an output LSB and then clipped to the representable range before it is registered on the output. Both sample streams use a valid/ready handshake. The filter takes no new sample until the previous result has been accepted. Coefficients are written through a simple address/data port, and a write counts only while the filter is idle.

Top module: `fir_cbuf_mac`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: An accepted sample is stored at the current write slot. The write pointer advances by one, modulo `TAPS`, when the result is accepted. No other stored sample moves, so results stay correct across every pointer wraparound.
- R3: Once `TAPS` samples have been accepted, every result equals the rounded and saturated value of the sum over n of `b[n]*x[k-n]`, where `x[k]` is the sample just accepted.
- R4: Rounding adds 2^(DATA_W-2) to the full-precision sum and then shifts right arithmetically by DATA_W-1 bits. For example, with DATA_W=8 the sums 64, 63, -64 and -65 give 1, 0, 0 and -1.
- R5: A rounded result above 2^(DATA_W-1)-1 is output as 2^(DATA_W-1)-1. A rounded result below -2^(DATA_W-1) is output as -2^(DATA_W-1).
- R6: Partial sums that exceed the data range do not corrupt the result, provided the final sum is representable within the guard bits.
- R7: `out_valid` rises exactly TAPS+2 clock cycles after the edge at which a sample is accepted.
- R8: `in_ready` stays 0 from the accepting edge until the edge at which the result is taken with `out_ready`.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged.
- R10: A coefficient write presented while `in_ready` is 0 has no effect.
- R11: A coefficient write in the idle state with `cfg_addr` = n sets coefficient `b[n]`, which multiplies the sample n positions older than the newest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Filter can take a sample |
| in_data | input | DATA_W | Input sample, two's-complement fraction |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Rounded, saturated result |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | $clog2(TAPS) | Coefficient index |
| cfg_data | input | DATA_W | Coefficient value |

## Verification
The bench builds the filter with 8-bit data, four taps and three guard bits. At this size every rounding tie and every saturation corner can be reached with a handful of hand-picked samples. One four-tap case drives a partial sum well beyond the range of a single product while the final value stays small. A long pseudo-random stream with periodic coefficient reloads wraps the write pointer about a hundred times. Each result is compared with an integer sum computed in the bench.

// File: rtl/fir_cbuf_pkg.sv
package fir_cbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_FIN,
    ST_OUT
  } fir_state_t;
endpackage

// File: rtl/fir_cbuf_ram.sv
module fir_cbuf_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_cbuf_macu.sv
module fir_cbuf_macu #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  a,
  input  logic signed [IN_W-1:0]  b,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [2*IN_W-1:0] prod;

  assign prod = a * b;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + ACC_W'(prod);
  end
endmodule

// File: rtl/fir_cbuf_rndsat.sv
module fir_cbuf_rndsat #(
  parameter int ACC_W = 36,
  parameter int OUT_W = 16
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OUT_W-1:0] y
);
  localparam int FRAC = OUT_W - 1;
  localparam int EXT_W = ACC_W + 1;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (FRAC - 1);
  localparam logic signed [EXT_W-1:0] VMAX = (EXT_W'(1) <<< (OUT_W - 1)) - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] VMIN = -(EXT_W'(1) <<< (OUT_W - 1));

  logic signed [EXT_W-1:0] rounded;
  logic signed [EXT_W-1:0] scaled;

  always_comb begin
    rounded = EXT_W'(acc) + HALF;
    scaled  = rounded >>> FRAC;
    if (scaled > VMAX)      y = VMAX[OUT_W-1:0];
    else if (scaled < VMIN) y = VMIN[OUT_W-1:0];
    else                    y = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/fir_cbuf_mac.sv
module fir_cbuf_mac
  import fir_cbuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  parameter int GUARD  = 4,
  localparam int PTR_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              cfg_we,
  input  logic [PTR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_data
);
  localparam int ACC_W = 2 * DATA_W + GUARD;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TAPS - 1);
  localparam logic [PTR_W:0]   TAPS_X = (PTR_W + 1)'(TAPS);

  fir_state_t state;
  logic [PTR_W-1:0] tap;
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] samp_raddr;
  logic [PTR_W:0]   wrap_sum;
  logic             accept;
  logic             coef_we;
  logic             mac_en;
  logic [DATA_W-1:0] coef_q;
  logic [DATA_W-1:0] samp_q;
  logic signed [ACC_W-1:0]  acc;
  logic signed [DATA_W-1:0] result;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign coef_we  = cfg_we && (state == ST_IDLE);

  // Sample for tap n lives n slots behind the newest one, modulo TAPS.
  always_comb begin
    wrap_sum = {1'b0, wptr} + TAPS_X - {1'b0, tap};
    if (wptr >= tap) samp_raddr = wptr - tap;
    else             samp_raddr = wrap_sum[PTR_W-1:0];
  end

  fir_cbuf_ram #(.WIDTH(DATA_W), .DEPTH(TAPS)) u_coef (
    .clk  (clk),
    .we   (coef_we),
    .waddr(cfg_addr),
    .wdata(cfg_data),
    .raddr(tap),
    .rdata(coef_q)
  );

  fir_cbuf_ram #(.WIDTH(DATA_W), .DEPTH(TAPS)) u_hist (
    .clk  (clk),
    .we   (accept),
    .waddr(wptr),
    .wdata(in_data),
    .raddr(samp_raddr),
    .rdata(samp_q)
  );

  fir_cbuf_macu #(.IN_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk),
    .rst(rst),
    .clr(accept),
    .en (mac_en),
    .a  ($signed(coef_q)),
    .b  ($signed(samp_q)),
    .acc(acc)
  );

  fir_cbuf_rndsat #(.ACC_W(ACC_W), .OUT_W(DATA_W)) u_rs (
    .acc(acc),
    .y  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tap       <= '0;
      wptr      <= '0;
      mac_en    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      mac_en <= (state == ST_RUN);
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            tap   <= '0;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tap == LAST) state <= ST_DRAIN;
          else             tap   <= tap + 1'b1;
        end
        ST_DRAIN: state <= ST_FIN;
        ST_FIN: begin
          out_data  <= result;
          out_valid <= 1'b1;
          state     <= ST_OUT;
        end
        ST_OUT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fir_cbuf_chk.sv
module fir_cbuf_chk #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 16,
  localparam int PTR_W = $clog2(TAPS)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [PTR_W-1:0]  wptr
);
  localparam logic [15:0] LAT = 16'(TAPS + 2);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TAPS - 1);

  logic [15:0] since_acc;

  always_ff @(posedge clk) begin
    if (rst)                         since_acc <= '0;
    else if (in_valid && in_ready)   since_acc <= '0;
    else if (!out_valid && since_acc != 16'hFFFF) since_acc <= since_acc + 16'd1;
  end

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> since_acc == LAT);

  assert_no_ready_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=>
      (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1)));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_ready) |=> $stable(wptr));
endmodule

bind fir_cbuf_mac fir_cbuf_chk #(.DATA_W(DATA_W), .TAPS(TAPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .wptr     (wptr)
);

// File: tb/fir_cbuf_mac_test.sv
module fir_cbuf_mac_test;
  localparam int DW = 8;
  localparam int NT = 4;
  localparam int GB = 3;
  localparam int AW = $clog2(NT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;

  always #2.5 clk = ~clk;

  fir_cbuf_mac #(.DATA_W(DW), .TAPS(NT), .GUARD(GB)) uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int coef [NT];
  int hist [NT];
  int n_push = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_out();
    int acc = 0;
    int r;
    for (int n = 0; n < NT; n++) acc += coef[n] * hist[n];
    r = (acc + (1 << (DW - 2))) >>> (DW - 1);
    if (r > (1 << (DW - 1)) - 1) r = (1 << (DW - 1)) - 1;
    if (r < -(1 << (DW - 1)))    r = -(1 << (DW - 1));
    return r;
  endfunction

  task automatic next_rand(output int v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    v = int'($signed(rng[7:0]));
  endtask

  // R11: coefficient index n maps to b[n]
  task automatic load_coef(input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(idx); cfg_data = DW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    coef[idx] = val;
  endtask

  task automatic push(input int x, input string tag, input bit poke, input int hold);
    int cnt = 0;
    bit rdy_seen = 1'b0;
    int exp_v;
    int got;
    for (int n = NT - 1; n > 0; n--) hist[n] = hist[n-1];
    hist[0] = x;
    n_push++;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = DW'(x);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && cnt < 100) begin
      if (in_ready) rdy_seen = 1'b1;
      if (poke && cnt == 0) begin
        cfg_we = 1'b1; cfg_addr = '0; cfg_data = DW'(8'h55);
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    cfg_we = 1'b0;
    chk(cnt == NT + 2, "R7 latency", cnt, NT + 2);
    chk(!rdy_seen, "R8 ready while busy", int'(rdy_seen), 0);
    got = int'($signed(out_data));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && int'($signed(out_data)) == got && !in_ready,
          "R9 hold", int'($signed(out_data)), got);
    end
    exp_v = model_out();
    if (n_push >= NT) chk(got == exp_v, tag, got, exp_v);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v;
    for (int n = 0; n < NT; n++) begin coef[n] = 0; hist[n] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);

    // R11 impulse response through distinct coefficients
    load_coef(0, 10); load_coef(1, -20); load_coef(2, 30); load_coef(3, -40);
    for (int i = 0; i < NT; i++) push(0, "R3 prime", 1'b0, 0);
    push(127, "R11 tap0", 1'b0, 0);
    push(0, "R11 tap1", 1'b0, 0);
    push(0, "R11 tap2", 1'b0, 0);
    push(0, "R11 tap3", 1'b0, 0);

    // R4 rounding ties on a single unit tap
    load_coef(0, 1); load_coef(1, 0); load_coef(2, 0); load_coef(3, 0);
    push(64, "R4 +64", 1'b0, 0);
    push(63, "R4 +63", 1'b0, 0);
    push(-64, "R4 -64", 1'b0, 0);
    push(-65, "R4 -65", 1'b0, 0);

    // R5 saturation both directions
    for (int n = 0; n < NT; n++) load_coef(n, 127);
    for (int i = 0; i < NT; i++) push(127, "R5 pos", 1'b0, 0);
    for (int n = 0; n < NT; n++) load_coef(n, -128);
    for (int i = 0; i < NT; i++) push(127, "R5 neg", 1'b0, 0);
    for (int i = 0; i < NT; i++) push(-128, "R5 negneg", 1'b0, 0);

    // R6 partial sums beyond range, small final sum
    load_coef(0, 127); load_coef(1, 127); load_coef(2, -128); load_coef(3, -128);
    for (int i = 0; i < NT; i++) push(127, "R6 guard", 1'b0, 0);

    // R10 writes while busy are ignored; R9 hold under backpressure
    push(50, "R10 poke", 1'b1, 3);
    push(-70, "R10 after", 1'b0, 5);
    push(33, "R10 after2", 1'b0, 0);

    // R2/R3 long random sweep with coefficient reloads and wraparound
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0)
        for (int n = 0; n < NT; n++) begin next_rand(v); load_coef(n, v); end
      next_rand(v);
      push(v, "R2 R3 sweep", 1'b0, (i % 37 == 0) ? 2 : 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule